// File: doc/BRIEF.md
# Mirror Driver Power-Sequencing Controller

This controller sits between an 8-bit host byte stream, delivered through a USB receive FIFO, and a bank of quad-output 12-bit DACs. Those DACs feed the high-voltage amplifiers of a deformable mirror with up to 124 electrodes. After the link comes up, the controller first powers the link and logic side. It then powers the amplifier supply. Only after that does it settle in a main state where it waits for control bytes.

In the main state, one control byte starts an update pass over every electrode channel. Each channel takes two host bytes, and each finished channel is written to the DAC output that the channel index selects. Other control bytes run a timed self test, return a status reply to the host or shut the amplifiers down in order. A watchdog ends an update pass that stalls. Losing the link at any point forces the power-down sequence. The FIFO's data-available flag is asynchronous and is synchronized before use.

Top module: `mirror_pwr_seq`

## Requirements
- R1: While reset is held and afterwards with `link_up` low, `link_pwr_en`, `amp_en`, `rx_rd`, `dac_wr` and `tx_wr` are all low.
- R2: When `link_up` is high in the off state, `link_pwr_en` goes high. `amp_en` stays low until `link_ready` is seen high.
- R3: `amp_en` goes high once `link_ready` is seen. No host byte is read (`rx_rd` stays low) until `amp_pwr_ok` is high and the main state is reached.
- R4: Control byte 0x52 starts an update pass. Each channel n takes two bytes: the first gives data bits [7:0], and bits [3:0] of the second give bits [11:8], while its bits [7:4] are ignored. One cycle after the second byte is read, `dac_wr` pulses for one cycle with `dac_data`, `dac_dev` = n/4 and `dac_out` = n%4.
- R5: The pass loads channels 0 to N_CH-1 in order (124 by default) and then returns to the main state.
- R6: During a pass, if `wd_limit` clock cycles go by with no byte read, the controller returns to main, makes no further DAC writes and sets the watchdog flag. The flag is cleared when the next pass starts.
- R7: Control byte 0x54 runs a self test of ST_CYCLES cycles. It then sends 0xA5 if `amp_pwr_ok` stayed high the whole time, or 0x5A if not, followed by 0x04.
- R8: Control byte 0x3F sends two bytes through `tx_wr`/`tx_data` while `tx_ready` is high. The first is a flags byte: bit7 = `amp_pwr_ok`, bit6 = `link_ready`, bit5 = last self test passed, bit4 = last pass ended by the watchdog, bits 3:0 zero. The second is the end marker 0x04.
- R9: Control byte 0x58 drops `amp_en` at once. `link_pwr_en` drops after `amp_pwr_ok` goes low. Power-up does not restart until `link_up` has gone low and come back high.
- R10: `link_up` going low in any powered state drops `amp_en` on the next cycle. `link_pwr_en` follows once `amp_pwr_ok` is low.
- R11: Any other byte received in the main state is consumed with no effect: no DAC write, no reply, and the amplifiers stay on.
- R12: The FIFO flag passes through a two-flop synchronizer. Reads are at least 4 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_up | input | 1 | Power present and cable connected |
| link_ready | input | 1 | USB module reports ready |
| amp_pwr_ok | input | 1 | Amplifier supply reports powered |
| rx_avail_a | input | 1 | Asynchronous FIFO data-available flag |
| rx_data | input | 8 | FIFO head byte |
| rx_rd | output | 1 | Pops the FIFO head at this clock edge |
| tx_ready | input | 1 | Host side can accept a byte |
| tx_wr | output | 1 | Byte write strobe to the host |
| tx_data | output | 8 | Byte to the host |
| wd_limit | input | 16 | Idle-cycle limit of the pass watchdog |
| link_pwr_en | output | 1 | Link and logic power enable |
| amp_en | output | 1 | Amplifier supply enable |
| dac_wr | output | 1 | DAC channel load strobe |
| dac_dev | output | 5 | DAC device index (n/4) |
| dac_out | output | 2 | Output within the device (n%4) |
| dac_data | output | 12 | Channel value |

## Verification
A byte pushed into the FIFO is read at the third rising edge after it appears, because the flag crosses two flops first. The command it carries therefore takes effect from that edge on. `amp_en` and `link_pwr_en` change on the edge after the condition that drives them. `dac_wr` is due exactly one cycle after the read of a channel's second byte, and reply bytes follow on consecutive cycles while `tx_ready` is high. The bench samples on the falling edge and waits margins longer than these latencies before it compares. Two timing rules are measured directly at every falling edge over the whole run: the one-cycle DAC latency and the 4-cycle read spacing.

// File: rtl/mps_pkg.sv
package mps_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_LINK_UP,
        S_AMP_UP,
        S_MAIN,
        S_RUN,
        S_SELFTEST,
        S_TX,
        S_AMP_DOWN
    } state_e;

    localparam logic [7:0] CMD_RUN      = 8'h52;
    localparam logic [7:0] CMD_SELFTEST = 8'h54;
    localparam logic [7:0] CMD_STATUS   = 8'h3F;
    localparam logic [7:0] CMD_SHUTDOWN = 8'h58;

    localparam logic [7:0] MSG_OK  = 8'hA5;
    localparam logic [7:0] MSG_ERR = 8'h5A;
    localparam logic [7:0] MSG_EOT = 8'h04;

endpackage

// File: rtl/mps_sync2.sv
module mps_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    output logic out_s
);
    logic ff1_q, ff2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff1_q <= 1'b0;
            ff2_q <= 1'b0;
        end else begin
            ff1_q <= in_a;
            ff2_q <= ff1_q;
        end
    end

    assign out_s = ff2_q;

    // R12: a rising synchronized flag was high at the input two edges earlier
    p_sync_depth_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_s) |-> $past(in_a, 2));
endmodule

// File: rtl/mps_watchdog.sv
module mps_watchdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            kick,
    input  logic [WD_W-1:0] limit,
    output logic            expired
);
    logic [WD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || kick)
            cnt_d = '0;
        else if (cnt_q != limit)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == limit);

    // R6: idle count never passes the limit
    p_wd_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit));
endmodule

// File: rtl/mps_chan_map.sv
module mps_chan_map #(
    parameter int N_CH  = 124,
    parameter int OUTS  = 4,
    parameter int CH_W  = 7,
    parameter int DEV_W = 5,
    parameter int OUT_W = 2
) (
    input  logic [CH_W-1:0]  idx,
    output logic [DEV_W-1:0] dev,
    output logic [OUT_W-1:0] outp
);
    generate
        if ((OUTS & (OUTS - 1)) == 0) begin : g_pow2
            assign outp = idx[OUT_W-1:0];
            assign dev  = DEV_W'(idx >> OUT_W);
        end else begin : g_div
            assign outp = OUT_W'(idx % CH_W'(OUTS));
            assign dev  = DEV_W'(idx / CH_W'(OUTS));
        end
    endgenerate

    // R4: device index stays inside the bank
    p_dev_range_r4: assert final (int'(idx) >= N_CH || int'(dev) < (N_CH + OUTS - 1) / OUTS);
endmodule

// File: rtl/mirror_pwr_seq.sv
module mirror_pwr_seq
    import mps_pkg::*;
#(
    parameter int N_CH      = 124,
    parameter int OUTS      = 4,
    parameter int DAC_W     = 12,
    parameter int WD_W      = 16,
    parameter int ST_CYCLES = 16,
    parameter int RD_GAP    = 3,
    localparam int N_DEV    = (N_CH + OUTS - 1) / OUTS,
    localparam int DEV_W    = $clog2(N_DEV),
    localparam int OUT_W    = $clog2(OUTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             link_ready,
    input  logic             amp_pwr_ok,
    input  logic             rx_avail_a,
    input  logic [7:0]       rx_data,
    output logic             rx_rd,
    input  logic             tx_ready,
    output logic             tx_wr,
    output logic [7:0]       tx_data,
    input  logic [WD_W-1:0]  wd_limit,
    output logic             link_pwr_en,
    output logic             amp_en,
    output logic             dac_wr,
    output logic [DEV_W-1:0] dac_dev,
    output logic [OUT_W-1:0] dac_out,
    output logic [DAC_W-1:0] dac_data
);
    localparam int CH_W  = $clog2(N_CH);
    localparam int ST_W  = $clog2(ST_CYCLES + 1);
    localparam int GAP_W = $clog2(RD_GAP + 1);
    localparam int HI_W  = DAC_W - 8;

    typedef struct packed {
        state_e           st;
        logic             armed;
        logic [CH_W-1:0]  ch;
        logic             hi_phase;
        logic [7:0]       lo;
        logic [GAP_W-1:0] gap;
        logic [ST_W-1:0]  st_cnt;
        logic             st_fail;
        logic             st_ok;
        logic             wd_trip;
        logic [7:0]       msg;
        logic             tx_idx;
        logic             tx_wr;
        logic [7:0]       tx_data;
        logic             dac_wr;
        logic [DAC_W-1:0] dac_data;
        logic [DEV_W-1:0] dac_dev;
        logic [OUT_W-1:0] dac_out;
    } regs_t;

    localparam regs_t REGS_RST = '{st: S_OFF, armed: 1'b1, default: '0};

    regs_t r_d, r_q;
    logic  rx_avail_s, rd_now, wd_exp;
    logic [DEV_W-1:0] map_dev;
    logic [OUT_W-1:0] map_out;

    mps_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_a  (rx_avail_a),
        .out_s (rx_avail_s)
    );

    mps_watchdog #(.WD_W(WD_W)) u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == S_RUN),
        .kick    (rd_now),
        .limit   (wd_limit),
        .expired (wd_exp)
    );

    mps_chan_map #(
        .N_CH(N_CH), .OUTS(OUTS), .CH_W(CH_W), .DEV_W(DEV_W), .OUT_W(OUT_W)
    ) u_map (
        .idx  (r_q.ch),
        .dev  (map_dev),
        .outp (map_out)
    );

    always_comb begin
        r_d        = r_q;
        r_d.tx_wr  = 1'b0;
        r_d.dac_wr = 1'b0;
        if (r_q.gap != '0)
            r_d.gap = r_q.gap - 1'b1;

        rd_now = link_up && rx_avail_s && (r_q.gap == '0) &&
                 ((r_q.st == S_MAIN) || (r_q.st == S_RUN));
        if (rd_now)
            r_d.gap = GAP_W'(RD_GAP);

        unique case (r_q.st)
            S_OFF: begin
                if (link_up && r_q.armed) r_d.st = S_LINK_UP;
            end
            S_LINK_UP: begin
                if (!link_up)        r_d.st = S_OFF;
                else if (link_ready) r_d.st = S_AMP_UP;
            end
            S_AMP_UP: begin
                if (!link_up)        r_d.st = S_AMP_DOWN;
                else if (amp_pwr_ok) r_d.st = S_MAIN;
            end
            S_MAIN: begin
                if (!link_up) begin
                    r_d.st = S_AMP_DOWN;
                end else if (rd_now) begin
                    case (rx_data)
                        CMD_RUN: begin
                            r_d.st       = S_RUN;
                            r_d.ch       = '0;
                            r_d.hi_phase = 1'b0;
                            r_d.wd_trip  = 1'b0;
                        end
                        CMD_SELFTEST: begin
                            r_d.st      = S_SELFTEST;
                            r_d.st_cnt  = '0;
                            r_d.st_fail = 1'b0;
                        end
                        CMD_STATUS: begin
                            r_d.st     = S_TX;
                            r_d.tx_idx = 1'b0;
                            r_d.msg    = {amp_pwr_ok, link_ready, r_q.st_ok, r_q.wd_trip, 4'h0};
                        end
                        CMD_SHUTDOWN: begin
                            r_d.st    = S_AMP_DOWN;
                            r_d.armed = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
            S_RUN: begin
                if (!link_up) begin
                    r_d.st = S_AMP_DOWN;
                end else if (rd_now) begin
                    if (!r_q.hi_phase) begin
                        r_d.lo       = rx_data;
                        r_d.hi_phase = 1'b1;
                    end else begin
                        r_d.hi_phase = 1'b0;
                        r_d.dac_wr   = 1'b1;
                        r_d.dac_data = {rx_data[HI_W-1:0], r_q.lo};
                        r_d.dac_dev  = map_dev;
                        r_d.dac_out  = map_out;
                        r_d.ch       = r_q.ch + 1'b1;
                        if (r_q.ch == CH_W'(N_CH - 1))
                            r_d.st = S_MAIN;
                    end
                end else if (wd_exp) begin
                    r_d.st      = S_MAIN;
                    r_d.wd_trip = 1'b1;
                end
            end
            S_SELFTEST: begin
                if (!link_up) begin
                    r_d.st = S_AMP_DOWN;
                end else begin
                    r_d.st_cnt  = r_q.st_cnt + 1'b1;
                    r_d.st_fail = r_q.st_fail | !amp_pwr_ok;
                    if (r_q.st_cnt == ST_W'(ST_CYCLES - 1)) begin
                        r_d.st_ok  = !(r_q.st_fail || !amp_pwr_ok);
                        r_d.msg    = (r_q.st_fail || !amp_pwr_ok) ? MSG_ERR : MSG_OK;
                        r_d.tx_idx = 1'b0;
                        r_d.st     = S_TX;
                    end
                end
            end
            S_TX: begin
                if (!link_up) begin
                    r_d.st = S_AMP_DOWN;
                end else if (tx_ready) begin
                    r_d.tx_wr   = 1'b1;
                    r_d.tx_data = r_q.tx_idx ? MSG_EOT : r_q.msg;
                    r_d.tx_idx  = 1'b1;
                    if (r_q.tx_idx) r_d.st = S_MAIN;
                end
            end
            S_AMP_DOWN: begin
                if (!amp_pwr_ok) r_d.st = S_OFF;
            end
            default: r_d.st = S_OFF;
        endcase

        if (!link_up)
            r_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign rx_rd       = rd_now;
    assign tx_wr       = r_q.tx_wr;
    assign tx_data     = r_q.tx_data;
    assign dac_wr      = r_q.dac_wr;
    assign dac_dev     = r_q.dac_dev;
    assign dac_out     = r_q.dac_out;
    assign dac_data    = r_q.dac_data;
    assign link_pwr_en = (r_q.st != S_OFF);
    assign amp_en      = (r_q.st == S_AMP_UP) || (r_q.st == S_MAIN) || (r_q.st == S_RUN) ||
                         (r_q.st == S_SELFTEST) || (r_q.st == S_TX);

    // R3: main is entered from amplifier power-up only with the supply reported on
    p_main_after_amp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_MAIN && $past(r_q.st) == S_AMP_UP) |-> $past(amp_pwr_ok));

    // R4: a DAC strobe follows a byte read on the previous cycle
    p_dac_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_wr |-> $past(rx_rd));

    // R6: an expired watchdog with no byte returns the pass to main
    p_wd_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RUN && wd_exp && !rx_rd && link_up) |=> (r_q.st == S_MAIN && !dac_wr));

    // R8: reply bytes are only written out of the transmit state
    p_tx_from_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> ($past(r_q.st) == S_TX && $past(tx_ready)));

    // R10: link loss removes amplifier enable on the next cycle
    p_link_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_up && amp_en) |=> !amp_en);

    // R12: reads are spaced at least four cycles apart
    p_rd_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |=> !rx_rd ##1 !rx_rd ##1 !rx_rd);
endmodule

// File: tb/mirror_pwr_seq_tb.sv
module mirror_pwr_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0, link_ready = 1'b0, amp_pwr_ok = 1'b0;
    logic        tx_ready = 1'b1;
    logic [15:0] wd_limit = 16'd20;
    logic        rx_avail_a, rx_rd, tx_wr, link_pwr_en, amp_en, dac_wr;
    logic [7:0]  rx_data, tx_data;
    logic [4:0]  dac_dev;
    logic [1:0]  dac_out;
    logic [11:0] dac_data;

    int vectors = 0, errors = 0;

    always #2 clk = ~clk;

    mirror_pwr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .link_ready(link_ready),
        .amp_pwr_ok(amp_pwr_ok), .rx_avail_a(rx_avail_a), .rx_data(rx_data),
        .rx_rd(rx_rd), .tx_ready(tx_ready), .tx_wr(tx_wr), .tx_data(tx_data),
        .wd_limit(wd_limit), .link_pwr_en(link_pwr_en), .amp_en(amp_en),
        .dac_wr(dac_wr), .dac_dev(dac_dev), .dac_out(dac_out), .dac_data(dac_data)
    );

    // Host FIFO model
    logic [7:0] fifo [0:1023];
    int wr_ptr = 0, rd_ptr = 0;
    assign rx_avail_a = (rd_ptr != wr_ptr);
    assign rx_data    = fifo[rd_ptr % 1024];
    always @(posedge clk) if (rx_rd) rd_ptr <= rd_ptr + 1;

    // Output recorders, sampled on the falling edge
    logic [7:0]  tx_log  [0:63];
    logic [11:0] dac_dat [0:511];
    logic [4:0]  dac_dv  [0:511];
    logic [1:0]  dac_ot  [0:511];
    int tx_n = 0, dac_n = 0, cyc = 0, last_rd = -100, pace_err = 0, lat_err = 0;
    logic prev_rd = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rx_rd) begin
            if (cyc - last_rd < 4) pace_err = pace_err + 1;
            last_rd = cyc;
        end
        if (dac_wr) begin
            dac_dat[dac_n % 512] = dac_data;
            dac_dv[dac_n % 512]  = dac_dev;
            dac_ot[dac_n % 512]  = dac_out;
            dac_n = dac_n + 1;
            if (!prev_rd) lat_err = lat_err + 1;
        end
        if (tx_wr) begin
            tx_log[tx_n % 64] = tx_data;
            tx_n = tx_n + 1;
        end
        prev_rd = rx_rd;
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        fifo[wr_ptr % 1024] = b;
        wr_ptr = wr_ptr + 1;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int chan_val(input int n);
        return (n * 37 + 5) % 4096;
    endfunction

    task automatic status_reply(input string req, input int flags);
        int base = tx_n;
        push(8'h3F);
        waitc(20);
        check({req, " reply count"}, tx_n - base, 2);
        check({req, " flags"}, tx_log[base % 64], flags);
        check({req, " eot"}, tx_log[(base + 1) % 64], 8'h04);
    endtask

    task automatic t_reset;
        waitc(3);
        check("R1 link_pwr_en", link_pwr_en, 0);
        check("R1 amp_en", amp_en, 0);
        check("R1 strobes", {rx_rd, dac_wr, tx_wr}, 0);
        rst_n = 1'b1;
        waitc(4);
        check("R1 off after reset", {link_pwr_en, amp_en}, 0);
    endtask

    task automatic t_powerup;
        link_up = 1'b1;
        waitc(3);
        check("R2 link_pwr_en", link_pwr_en, 1);
        check("R2 amp_en waits ready", amp_en, 0);
        push(8'h3F);
        waitc(10);
        check("R3 no read before main", rd_ptr, 0);
        link_ready = 1'b1;
        waitc(3);
        check("R3 amp_en", amp_en, 1);
        waitc(5);
        check("R3 still no read", rd_ptr, 0);
        amp_pwr_ok = 1'b1;
        waitc(20);
        check("R3 byte read in main", rd_ptr, 1);
        check("R8 reply count", tx_n, 2);
        check("R8 flags", tx_log[0], 8'hC0);
        check("R8 eot", tx_log[1], 8'h04);
    endtask

    task automatic t_ignore;
        int tb = tx_n, db = dac_n;
        push(8'h00);
        push(8'h41);
        waitc(25);
        check("R11 consumed", rd_ptr, wr_ptr);
        check("R11 no reply", tx_n, tb);
        check("R11 no dac", dac_n, db);
        check("R11 amp_en", amp_en, 1);
        status_reply("R11 still main", 8'hC0);
    endtask

    task automatic t_run;
        int db = dac_n;
        int bad = 0;
        push(8'h52);
        for (int n = 0; n < 124; n++) begin
            int v = chan_val(n);
            push(8'(v & 8'hFF));
            push(8'hA0 | 8'(v >> 8));
        end
        waitc(1100);
        check("R5 channel count", dac_n - db, 124);
        for (int n = 0; n < 124; n++) begin
            int k = (db + n) % 512;
            check("R4 data", dac_dat[k], chan_val(n));
            if (dac_dv[k] != 5'(n / 4) || dac_ot[k] != 2'(n % 4)) bad++;
        end
        check("R4 device/output mapping", bad, 0);
        check("R4 one-cycle dac latency", lat_err, 0);
        status_reply("R5 back in main", 8'hC0);
    endtask

    task automatic t_watchdog;
        int db = dac_n;
        push(8'h52);
        push(8'h34); push(8'h02); push(8'h99);
        waitc(80);
        check("R6 one channel loaded", dac_n - db, 1);
        check("R6 data", dac_dat[db % 512], 12'h234);
        status_reply("R6 returned to main", 8'hD0);
        check("R6 no extra dac", dac_n - db, 1);
    endtask

    task automatic t_selftest;
        int base = tx_n;
        push(8'h54);
        waitc(40);
        check("R7 ok count", tx_n - base, 2);
        check("R7 ok code", tx_log[base % 64], 8'hA5);
        check("R7 ok eot", tx_log[(base + 1) % 64], 8'h04);
        status_reply("R8 self-test flag", 8'hF0);
        base = tx_n;
        push(8'h54);
        waitc(8);
        amp_pwr_ok = 1'b0;
        waitc(3);
        amp_pwr_ok = 1'b1;
        waitc(40);
        check("R7 err count", tx_n - base, 2);
        check("R7 err code", tx_log[base % 64], 8'h5A);
        check("R7 err eot", tx_log[(base + 1) % 64], 8'h04);
    endtask

    task automatic t_shutdown;
        push(8'h58);
        waitc(8);
        check("R9 amp_en dropped", amp_en, 0);
        check("R9 link held", link_pwr_en, 1);
        amp_pwr_ok = 1'b0;
        waitc(3);
        check("R9 link off", link_pwr_en, 0);
        waitc(20);
        check("R9 no restart", link_pwr_en, 0);
        link_up = 1'b0;
        waitc(3);
        link_up = 1'b1;
        waitc(3);
        check("R9 restart", {link_pwr_en, amp_en}, 2'b11);
        amp_pwr_ok = 1'b1;
        waitc(5);
    endtask

    task automatic t_link_loss;
        link_up = 1'b0;
        waitc(2);
        check("R10 amp_en off", amp_en, 0);
        check("R10 link held", link_pwr_en, 1);
        amp_pwr_ok = 1'b0;
        waitc(3);
        check("R10 link off", link_pwr_en, 0);
        check("R12 read spacing", pace_err, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_ignore();
        t_run();
        t_watchdog();
        t_selftest();
        t_shutdown();
        t_link_loss();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule